// File: doc/BRIEF.md
# PHY Status LED Selector

This block turns the status signals of a 10/100 Ethernet transceiver into two active-low LED pin levels. The status signals are link up, transmit and receive activity, collision, line speed, duplex and auto-negotiation in progress. Each LED has its own configuration field, supplied as a plain register input. The field picks which indicator the LED shows: one of eight single functions, or a combined link/activity function that is steady on for link and blinks while traffic is seen.

Activity and collision events are often a single clock wide. Each one is stretched to a minimum on-time so that it is visible. A free-running divider sets the blink rate. The context signals gate the indicators: collision is shown only in half duplex, and the speed indicators stay dark while auto-negotiation runs. Both pins come from a register stage, so every pin change appears one clock after the inputs that cause it.

Top module: `phy_led_ctrl`

## Requirements
- R1: Both LED pins are active low (0 = lit). While rst_ni is low, both pins are held at 1 (dark).
- R2: Function code 0 (link) lights the LED in the cycle after link_up_i is 1, and leaves it dark in the cycle after link_up_i is 0.
- R3: Function code 1 (activity) lights the LED on transmit or receive activity. A single-cycle event keeps the LED lit for exactly STRETCH_CYC cycles, starting one cycle after the event.
- R4: Function code 2 lights the LED on transmit activity only, and code 3 lights it on receive activity only. Both use the same stretching as R3. Activity on the other direction leaves the LED dark.
- R5: Function code 4 lights the LED on a stretched collision event while full_dup_i is 0. While full_dup_i is 1, the LED is held dark.
- R6: Function code 5 lights the LED when the link is up at 100 Mb/s (speed100_i=1) and auto-negotiation is idle. Code 6 lights it when the link is up at 10 Mb/s (speed100_i=0) and auto-negotiation is idle. While aneg_busy_i is 1, both codes stay dark.
- R7: Function code 7 lights the LED when full_dup_i is 1 and leaves it dark when full_dup_i is 0.
- R8: When the link/activity enable of an LED is 1, its function code is ignored. With the link down the LED is dark. With the link up and no stretched activity, the LED is steadily lit.
- R9: In link/activity mode, while the link is up and stretched activity is present, the LED alternates between dark and lit. Each phase lasts BLINK_HALF cycles. Once the stretched activity ends, the LED returns to steady on.
- R10: The two LEDs are configured and driven independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link to far-end PHY is up |
| tx_act_i | input | 1 | Transmit activity event |
| rx_act_i | input | 1 | Receive activity event |
| col_i | input | 1 | Collision event |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup_i | input | 1 | 1 = full duplex |
| aneg_busy_i | input | 1 | Auto-negotiation in progress |
| led0_fn_i | input | 3 | LED0 function code (0..7) |
| led0_la_en_i | input | 1 | LED0 link/activity mode enable |
| led1_fn_i | input | 3 | LED1 function code (0..7) |
| led1_la_en_i | input | 1 | LED1 link/activity mode enable |
| led0_no | output | 1 | LED0 pin, active low |
| led1_no | output | 1 | LED1 pin, active low |

## Verification
The bench sweeps every function code on LED0 against all 128 steady levels of the seven status inputs. At the same time it drives LED1 with the complementary code, so a result crossed between LEDs or between codes shows up. This sweep separates the gating rules from one another: duplex against collision, auto-negotiation against speed, and link against the speed codes. Single-cycle pulses on each event input measure the exact stretched on-time and confirm that transmit and receive stay separate. In link/activity mode the bench measures the phase lengths of the blink and checks the dark level with the link down. It also checks the return to steady on after traffic stops.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  typedef enum logic [2:0] {
    FN_LINK  = 3'd0,
    FN_ACT   = 3'd1,
    FN_TX    = 3'd2,
    FN_RX    = 3'd3,
    FN_COL   = 3'd4,
    FN_SPD100 = 3'd5,
    FN_SPD10 = 3'd6,
    FN_FDX   = 3'd7
  } led_fn_e;

  // status after event stretching, shared by both selectors
  typedef struct packed {
    logic link;
    logic tx;
    logic rx;
    logic col;
    logic spd100;
    logic fdx;
    logic aneg;
  } led_ctx_t;

  localparam int NUM_EVT = 3;
  localparam int NUM_LED = 2;

endpackage

// File: rtl/phy_led_stretch.sv
module phy_led_stretch #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic str_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (evt_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // event cycle plus CYC-1 cycles of hold
  assign str_o = evt_i | (cnt_q != '0);

endmodule

// File: rtl/phy_led_blink.sv
module phy_led_blink #(
  parameter int HALF = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/phy_led_sel.sv
module phy_led_sel
  import phy_led_pkg::*;
(
  input  led_ctx_t   ctx_i,
  input  logic [2:0] fn_i,
  input  logic       la_en_i,
  input  logic       blink_i,
  output logic       lit_o
);
  logic act;
  logic fn_lit;
  logic la_lit;

  assign act = ctx_i.tx | ctx_i.rx;

  always_comb begin
    unique case (led_fn_e'(fn_i))
      FN_LINK:   fn_lit = ctx_i.link;
      FN_ACT:    fn_lit = act;
      FN_TX:     fn_lit = ctx_i.tx;
      FN_RX:     fn_lit = ctx_i.rx;
      FN_COL:    fn_lit = ctx_i.col & ~ctx_i.fdx;
      FN_SPD100: fn_lit = ctx_i.link & ctx_i.spd100 & ~ctx_i.aneg;
      FN_SPD10:  fn_lit = ctx_i.link & ~ctx_i.spd100 & ~ctx_i.aneg;
      FN_FDX:    fn_lit = ctx_i.fdx;
      default:   fn_lit = 1'b0;
    endcase
  end

  // steady on for link, blink phase gates it while traffic is stretched
  assign la_lit = ctx_i.link & (~act | blink_i);

  assign lit_o = la_en_i ? la_lit : fn_lit;

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int STRETCH_CYC = 1250000,
  parameter int BLINK_HALF  = 2500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_up_i,
  input  logic       tx_act_i,
  input  logic       rx_act_i,
  input  logic       col_i,
  input  logic       speed100_i,
  input  logic       full_dup_i,
  input  logic       aneg_busy_i,
  input  logic [2:0] led0_fn_i,
  input  logic       led0_la_en_i,
  input  logic [2:0] led1_fn_i,
  input  logic       led1_la_en_i,
  output logic       led0_no,
  output logic       led1_no
);
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] evt_str;
  logic               blink;
  led_ctx_t           ctx;
  logic [2:0]         fn_a  [NUM_LED];
  logic               la_a  [NUM_LED];
  logic [NUM_LED-1:0] lit;
  logic [NUM_LED-1:0] led_nq;

  assign evt = {col_i, rx_act_i, tx_act_i};

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    phy_led_stretch #(.CYC(STRETCH_CYC)) u_str (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt[e]),
      .str_o (evt_str[e])
    );
  end

  phy_led_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(blink)
  );

  assign ctx.link   = link_up_i;
  assign ctx.tx     = evt_str[0];
  assign ctx.rx     = evt_str[1];
  assign ctx.col    = evt_str[2];
  assign ctx.spd100 = speed100_i;
  assign ctx.fdx    = full_dup_i;
  assign ctx.aneg   = aneg_busy_i;

  assign fn_a[0] = led0_fn_i;
  assign fn_a[1] = led1_fn_i;
  assign la_a[0] = led0_la_en_i;
  assign la_a[1] = led1_la_en_i;

  for (genvar l = 0; l < NUM_LED; l++) begin : g_led
    phy_led_sel u_sel (
      .ctx_i  (ctx),
      .fn_i   (fn_a[l]),
      .la_en_i(la_a[l]),
      .blink_i(blink),
      .lit_o  (lit[l])
    );
  end

  // registered pins, dark in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_nq <= '1;
    else         led_nq <= ~lit;
  end

  assign led0_no = led_nq[0];
  assign led1_no = led_nq[1];

endmodule

// File: rtl/phy_led_ctrl_chk.sv
module phy_led_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       link_up_i,
  input logic       tx_act_i,
  input logic       full_dup_i,
  input logic       aneg_busy_i,
  input logic [2:0] led0_fn_i,
  input logic       led0_la_en_i,
  input logic [2:0] led1_fn_i,
  input logic       led1_la_en_i,
  input logic       led0_no,
  input logic       led1_no
);

  AST_LINK_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && led0_fn_i == 3'd0 && !led0_la_en_i) |-> (led0_no == !$past(link_up_i))); // R2

  AST_TX_LIGHTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && led0_fn_i == 3'd2 && !led0_la_en_i && tx_act_i) |-> !led0_no); // R4

  AST_COL_FDX_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && led0_fn_i == 3'd4 && !led0_la_en_i && full_dup_i) |-> led0_no); // R5

  AST_SPD_ANEG_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && (led0_fn_i == 3'd5 || led0_fn_i == 3'd6) && !led0_la_en_i && aneg_busy_i)
    |-> led0_no); // R6

  AST_FDX_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && led1_fn_i == 3'd7 && !led1_la_en_i) |-> (led1_no == !$past(full_dup_i))); // R7

  AST_LA_LINK_DOWN_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && led1_la_en_i && !link_up_i) |-> led1_no); // R8

endmodule

bind phy_led_ctrl phy_led_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .link_up_i   (link_up_i),
  .tx_act_i    (tx_act_i),
  .full_dup_i  (full_dup_i),
  .aneg_busy_i (aneg_busy_i),
  .led0_fn_i   (led0_fn_i),
  .led0_la_en_i(led0_la_en_i),
  .led1_fn_i   (led1_fn_i),
  .led1_la_en_i(led1_la_en_i),
  .led0_no     (led0_no),
  .led1_no     (led1_no)
);

// File: tb/phy_led_ctrl_tb.sv
`timescale 1ns/1ps
module phy_led_ctrl_tb;
  localparam int S  = 4;
  localparam int BH = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic link_up_i = 0, tx_act_i = 0, rx_act_i = 0, col_i = 0;
  logic speed100_i = 0, full_dup_i = 0, aneg_busy_i = 0;
  logic [2:0] led0_fn_i = 3'd0, led1_fn_i = 3'd1;
  logic led0_la_en_i = 0, led1_la_en_i = 0;
  logic led0_no, led1_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phy_led_ctrl #(.STRETCH_CYC(S), .BLINK_HALF(BH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .link_up_i(link_up_i), .tx_act_i(tx_act_i),
    .rx_act_i(rx_act_i), .col_i(col_i), .speed100_i(speed100_i),
    .full_dup_i(full_dup_i), .aneg_busy_i(aneg_busy_i),
    .led0_fn_i(led0_fn_i), .led0_la_en_i(led0_la_en_i),
    .led1_fn_i(led1_fn_i), .led1_la_en_i(led1_la_en_i),
    .led0_no(led0_no), .led1_no(led1_no));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // lit level from the requirements, activity inputs held steady
  function automatic bit exp_lit(input int fn, input bit lk, input bit tx, input bit rx,
                                 input bit cl, input bit sp, input bit fd, input bit an);
    case (fn)
      0: return lk;
      1: return tx | rx;
      2: return tx;
      3: return rx;
      4: return cl & !fd;
      5: return lk & sp & !an;
      6: return lk & !sp & !an;
      default: return fd;
    endcase
  endfunction

  task automatic pulse_count(input int which, input bit use_led1, output int cnt);
    case (which)
      0: tx_act_i = 1;
      1: rx_act_i = 1;
      default: col_i = 1;
    endcase
    tick();
    tx_act_i = 0; rx_act_i = 0; col_i = 0;
    cnt = 0;
    for (int i = 0; i < S + 3; i++) begin
      if (!(use_led1 ? led1_no : led0_no)) cnt++;
      tick();
    end
  endtask

  initial begin
    #(5.0 * 200000);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    n_chk++; n_fail++;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    link_up_i = 1;
    repeat (3) tick();
    check(led0_no && led1_no, "R1 reset dark", {led0_no, led1_no}, 3);
    rst_ni = 1;
    tick();
    check(!led0_no, "R2 link lit after reset", led0_no, 0);

    // R2..R7, R10: full sweep of codes against steady status levels
    for (int fn = 0; fn < 8; fn++) begin
      for (int v = 0; v < 128; v++) begin
        led0_fn_i = 3'(fn);
        led1_fn_i = 3'(7 - fn);
        link_up_i = v[0]; tx_act_i = v[1]; rx_act_i = v[2]; col_i = v[3];
        speed100_i = v[4]; full_dup_i = v[5]; aneg_busy_i = v[6];
        repeat (S + 2) tick();
        begin
          bit e0, e1;
          e0 = exp_lit(fn, v[0], v[1], v[2], v[3], v[4], v[5], v[6]);
          e1 = exp_lit(7 - fn, v[0], v[1], v[2], v[3], v[4], v[5], v[6]);
          check(led0_no == !e0, "R2-R7 sweep led0", led0_no, !e0);
          check(led1_no == !e1, "R10 sweep led1", led1_no, !e1);
        end
      end
    end
    tx_act_i = 0; rx_act_i = 0; col_i = 0; full_dup_i = 0; aneg_busy_i = 0;
    repeat (S + 2) tick();

    // R3: single tx / rx pulse stretched to S cycles
    led0_fn_i = 3'd1; led1_fn_i = 3'd2;
    pulse_count(0, 0, cnt);
    check(cnt == S, "R3 tx pulse stretch", cnt, S);
    pulse_count(1, 0, cnt);
    check(cnt == S, "R3 rx pulse stretch", cnt, S);
    // R4: rx pulse on tx-only LED stays dark, rx-only LED lights S cycles
    led0_fn_i = 3'd3; led1_fn_i = 3'd2;
    pulse_count(1, 1, cnt);
    check(cnt == 0, "R4 tx-only ignores rx", cnt, 0);
    pulse_count(1, 0, cnt);
    check(cnt == S, "R4 rx-only pulse", cnt, S);
    // R5: collision pulse, half then full duplex
    led0_fn_i = 3'd4;
    full_dup_i = 0;
    pulse_count(2, 0, cnt);
    check(cnt == S, "R5 collision half duplex", cnt, S);
    full_dup_i = 1;
    pulse_count(2, 0, cnt);
    check(cnt == 0, "R5 collision full duplex dark", cnt, 0);
    full_dup_i = 0;

    // R8: link/activity overrides code, link down dark
    led0_la_en_i = 1; led0_fn_i = 3'd7; full_dup_i = 1;
    link_up_i = 0; tx_act_i = 1;
    tick();
    cnt = 0;
    for (int i = 0; i < 3 * BH; i++) begin
      if (!led0_no) cnt++;
      tick();
    end
    check(cnt == 0, "R8 link down dark", cnt, 0);
    tx_act_i = 0; link_up_i = 1;
    repeat (S + 2) tick();
    cnt = 0;
    for (int i = 0; i < 3 * BH; i++) begin
      if (led0_no) cnt++;
      tick();
    end
    check(cnt == 0, "R8 link up steady on", cnt, 0);

    // R9: blink phases of BH cycles while activity held
    tx_act_i = 1;
    tick();
    begin
      int runs = 0;
      int len = 0;
      logic prev;
      prev = led0_no;
      for (int i = 0; i < 7 * BH; i++) begin
        if (led0_no == prev) len++;
        else begin
          if (runs > 0) check(len == BH, "R9 blink phase length", len, BH);
          runs++;
          len = 1;
          prev = led0_no;
        end
        tick();
      end
      check(runs >= 5, "R9 blink toggles", runs, 5);
    end
    tx_act_i = 0;
    repeat (S + 2) tick();
    cnt = 0;
    for (int i = 0; i < 3 * BH; i++) begin
      if (led0_no) cnt++;
      tick();
    end
    check(cnt == 0, "R9 back to steady on", cnt, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule